// File: doc/BRIEF.md
# Coprocessor Instruction Dispatch Controller

This block sits beside a CPU decode stage and watches each instruction word while the CPU decoder sees the same word. When the CPU does not take an instruction, the block says in that same cycle whether the word belongs to the coprocessor. If it does not, the CPU gets a trap indication for an invalid instruction. A recognised instruction is captured together with its two source operands. The whole instruction word and both operands are then offered to a coprocessor that runs on its own slower clock.

The handover crosses the clock boundary with toggle request and acknowledge signals. Each direction has its own two-flop synchroniser. The captured word and operands stay unchanged until the acknowledge comes back. Each table entry has a class, and the class sets how the CPU is treated:
- An autonomous operation lets the CPU keep issuing.
- A blocking operation stalls the CPU and holds off interrupts until it completes.
- A non-blocking operation stalls the CPU, but an interrupt may still be taken. The interrupt then cancels the coprocessor work.

The table also marks each entry with whether it returns a result. A result is handed back in the cycle in which the stall ends. Only one operation is in flight at a time.

Top module: `cop_dispatch`

## Requirements
- R1: With `dec_valid` high and `cpu_claim` low, `dec_accept` rises in the same cycle when instruction bits [31:26] equal 6'h04 and bits [5:0] select a populated table entry; otherwise `dec_trap` rises in the same cycle. With `cpu_claim` high or `dec_valid` low, neither output is asserted.
- R2: The default table has eight entries. Entries 0, 1 and 6 are autonomous; 2 and 3 are blocking; 4 and 5 are non-blocking. Only entries 2 and 4 return a result. Entry 7 and every selector of 8 or more are unrecognised. The other bits of the word do not affect decode.
- R3: An instruction accepted while the block is idle is presented on `cop_instr`, `cop_opa` and `cop_opb` with `cop_valid` high. The values are those present at acceptance, and they stay stable until the coprocessor answers with `cop_done` or the operation is flushed.
- R4: An autonomous operation never raises `cpu_stall` and never produces `res_valid`.
- R5: A blocking or non-blocking operation raises `cpu_stall` from the cycle after acceptance until its completion is seen. For a result-returning entry, `res_valid` pulses for one cycle with `res_data` equal to `cop_result`, in the first cycle in which `cpu_stall` is low again.
- R6: While an operation is in flight, a recognised instruction raises `dec_hold` together with `dec_accept`, and nothing is sent to the coprocessor.
- R7: While a blocking operation is in flight, `irq_take` stays low even if `irq_req` is high. When the block is idle, `irq_take` follows `irq_req`.
- R8: When `irq_req` arrives during a non-blocking operation, `irq_take` and `flush` rise in the same cycle and `cpu_stall` falls in the next cycle. The coprocessor then sees one `cop_flush` pulse. No result is returned. New instructions get `dec_hold` until the cancelled operation has been acknowledged.
- R9: After reset, `cpu_stall`, `res_valid`, `flush`, `cop_valid` and `cop_flush` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | CPU-domain asynchronous active-low reset |
| cop_clk | input | 1 | Coprocessor clock, slower than `clk` |
| cop_rst_n | input | 1 | Coprocessor-domain asynchronous active-low reset |
| dec_valid | input | 1 | An instruction word is in the decode stage |
| dec_instr | input | 32 | Instruction word in decode |
| cpu_claim | input | 1 | The CPU decoder owns this instruction |
| dec_accept | output | 1 | Same-cycle recognition of a coprocessor instruction |
| dec_trap | output | 1 | Neither the CPU nor this block owns the instruction |
| dec_hold | output | 1 | Recognised, but must wait because an operation is in flight |
| src_a | input | 32 | First source operand from the register file |
| src_b | input | 32 | Second source operand from the register file |
| cpu_stall | output | 1 | Holds the CPU pipeline during a non-autonomous operation |
| irq_req | input | 1 | Pending interrupt or asynchronous exception |
| irq_take | output | 1 | The pending interrupt may be taken now |
| flush | output | 1 | Cancels a non-blocking operation in favour of the interrupt |
| res_valid | output | 1 | One-cycle result write-back strobe |
| res_data | output | 32 | Result value for write-back |
| cop_valid | output | 1 | Operation offered to the coprocessor (coprocessor clock) |
| cop_instr | output | 32 | Instruction word for the coprocessor |
| cop_opa | output | 32 | First operand for the coprocessor |
| cop_opb | output | 32 | Second operand for the coprocessor |
| cop_done | input | 1 | Coprocessor completion, valid only while `cop_valid` is high |
| cop_result | input | 32 | Coprocessor result, sampled with `cop_done` |
| cop_flush | output | 1 | One-cycle cancel of the offered operation (coprocessor clock) |

## Verification
The assertions assume that the coprocessor raises `cop_done` only while `cop_valid` is high. They also assume that the two clocks are unrelated but that `cop_clk` is slower, so that one toggle is never missed. The bench coprocessor model meets both conditions: it counts latency only while `cop_valid` is high and drives `cop_done` on the falling coprocessor edge. The bench clocks the coprocessor at a third of the CPU rate with a phase offset. The bench drives decode inputs away from the CPU edge and clears `dec_valid` before the next edge, so every same-cycle decode check runs while the block is idle.

// File: rtl/cdp_pkg.sv
package cdp_pkg;

  // Execution class of a table entry; CLS_NONE marks an empty slot.
  typedef enum logic [1:0] {
    CLS_AUTO = 2'b00,
    CLS_BLK  = 2'b01,
    CLS_NBLK = 2'b10,
    CLS_NONE = 2'b11
  } xcls_e;

  // CPU-side dispatch state.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_RUN   = 2'b01,
    ST_DRAIN = 2'b10
  } cst_e;

endpackage

// File: rtl/cdp_decode.sv
module cdp_decode
  import cdp_pkg::*;
#(
  parameter int                    N_ENT     = 8,
  parameter int                    PRI_W     = 6,
  parameter int                    EXT_W     = 6,
  parameter logic [PRI_W-1:0]      PRI_CODE  = 6'h04,
  parameter logic [2*N_ENT-1:0]    CLASS_MAP = 16'hCA50,
  parameter logic [N_ENT-1:0]      WB_MAP    = 8'h14
) (
  input  logic [PRI_W-1:0] pri,
  input  logic [EXT_W-1:0] ext,
  output logic             recog,
  output xcls_e            cls,
  output logic             wb
);

  logic [N_ENT-1:0] hit;

  // One comparator per populated slot.
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    localparam logic [1:0] ECLS = CLASS_MAP[2*g +: 2];
    assign hit[g] = (ext == EXT_W'(g)) && (ECLS != CLS_NONE);
  end

  always_comb begin
    cls = CLS_NONE;
    wb  = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (hit[i]) begin
        cls = xcls_e'(CLASS_MAP[2*i +: 2]);
        // Autonomous entries never return a result.
        wb  = WB_MAP[i] && (CLASS_MAP[2*i +: 2] != CLS_AUTO);
      end
    end
  end

  assign recog = (pri == PRI_CODE) && (|hit);

endmodule

// File: rtl/cdp_sync.sv
module cdp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [STAGES-1:0][WIDTH-1:0] pipe_d;

  assign pipe_d = {pipe_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/cdp_cpu_ctrl.sv
module cdp_cpu_ctrl
  import cdp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic            cpu_claim,
  input  logic [XLEN-1:0] dec_instr,
  input  logic            recog,
  input  xcls_e           cls_in,
  input  logic            wb_in,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic            irq_req,
  input  logic            ack_tog_s,
  input  logic [XLEN-1:0] res_in,
  output logic            dec_accept,
  output logic            dec_trap,
  output logic            dec_hold,
  output logic            cpu_stall,
  output logic            irq_take,
  output logic            flush,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data,
  output logic            req_tog,
  output logic            flush_tog,
  output logic [XLEN-1:0] pay_instr,
  output logic [XLEN-1:0] pay_opa,
  output logic [XLEN-1:0] pay_opb
);

  cst_e            state_q, state_d;
  xcls_e           cls_q, cls_d;
  logic            wb_q, wb_d;
  logic            req_tog_q, req_tog_d;
  logic            flush_tog_q, flush_tog_d;
  logic            ack_seen_q;
  logic            pay_ld, res_ld;
  logic            res_valid_q;
  logic [XLEN-1:0] res_data_q;
  logic [XLEN-1:0] pay_instr_q, pay_opa_q, pay_opb_q;

  logic free_slot, busy, issue, ack_edge, blk_run, nb_run, flush_now;

  // Same-cycle claim-or-trap decision.
  assign free_slot  = dec_valid && !cpu_claim;
  assign dec_accept = free_slot && recog;
  assign dec_trap   = free_slot && !recog;
  assign busy       = (state_q != ST_IDLE);
  assign issue      = dec_accept && !busy;
  assign dec_hold   = dec_accept && busy;

  assign ack_edge   = ack_tog_s ^ ack_seen_q;
  assign blk_run    = (state_q == ST_RUN) && (cls_q == CLS_BLK);
  assign nb_run     = (state_q == ST_RUN) && (cls_q == CLS_NBLK);
  assign cpu_stall  = (state_q == ST_RUN) && (cls_q != CLS_AUTO);
  assign irq_take   = irq_req && !blk_run;
  // Completion arriving in the same cycle wins over cancellation.
  assign flush_now  = nb_run && irq_req && !ack_edge;
  assign flush      = flush_now;

  always_comb begin
    state_d     = state_q;
    cls_d       = cls_q;
    wb_d        = wb_q;
    req_tog_d   = req_tog_q;
    flush_tog_d = flush_tog_q;
    pay_ld      = 1'b0;
    res_ld      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (issue) begin
          state_d   = ST_RUN;
          cls_d     = cls_in;
          wb_d      = wb_in;
          req_tog_d = ~req_tog_q;
          pay_ld    = 1'b1;
        end
      end
      ST_RUN: begin
        if (ack_edge) begin
          state_d = ST_IDLE;
          res_ld  = wb_q;
        end else if (flush_now) begin
          state_d     = ST_DRAIN;
          flush_tog_d = ~flush_tog_q;
        end
      end
      ST_DRAIN: begin
        if (ack_edge) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cls_q       <= CLS_AUTO;
      wb_q        <= 1'b0;
      req_tog_q   <= 1'b0;
      flush_tog_q <= 1'b0;
      ack_seen_q  <= 1'b0;
      res_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      cls_q       <= cls_d;
      wb_q        <= wb_d;
      req_tog_q   <= req_tog_d;
      flush_tog_q <= flush_tog_d;
      ack_seen_q  <= ack_tog_s;
      res_valid_q <= res_ld;
    end
  end

  // Payload held from issue until the next issue.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_instr_q <= '0;
      pay_opa_q   <= '0;
      pay_opb_q   <= '0;
    end else if (pay_ld) begin
      pay_instr_q <= dec_instr;
      pay_opa_q   <= src_a;
      pay_opb_q   <= src_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_data_q <= '0;
    else if (res_ld) res_data_q <= res_in;
  end

  assign res_valid = res_valid_q;
  assign res_data  = res_data_q;
  assign req_tog   = req_tog_q;
  assign flush_tog = flush_tog_q;
  assign pay_instr = pay_instr_q;
  assign pay_opa   = pay_opa_q;
  assign pay_opb   = pay_opb_q;

  // R6
  hold_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hold |=> $stable(req_tog_q));

  // R5
  res_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(cpu_stall));

  // R8
  flush_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!cpu_stall && state_q == ST_DRAIN));

endmodule

// File: rtl/cdp_cop_port.sv
module cdp_cop_port #(
  parameter int XLEN = 32
) (
  input  logic            cop_clk,
  input  logic            cop_rst_n,
  input  logic            req_tog_s,
  input  logic            flush_tog_s,
  input  logic [XLEN-1:0] pay_instr,
  input  logic [XLEN-1:0] pay_opa,
  input  logic [XLEN-1:0] pay_opb,
  input  logic            cop_done,
  input  logic [XLEN-1:0] cop_result,
  output logic            cop_valid,
  output logic            cop_flush,
  output logic [XLEN-1:0] cop_instr,
  output logic [XLEN-1:0] cop_opa,
  output logic [XLEN-1:0] cop_opb,
  output logic            ack_tog,
  output logic [XLEN-1:0] res_hold
);

  logic            ack_q, ack_d;
  logic            fseen_q, fseen_d;
  logic [XLEN-1:0] res_q;
  logic            res_en;
  logic            pending, flush_pend;

  assign pending    = req_tog_s ^ ack_q;
  assign flush_pend = flush_tog_s ^ fseen_q;
  assign cop_valid  = pending && !flush_pend;
  assign cop_flush  = pending && flush_pend;
  assign res_en     = cop_valid && cop_done;

  always_comb begin
    ack_d   = ack_q;
    fseen_d = fseen_q;
    // A flush seen while nothing is pending is stale and only consumed.
    if (flush_pend) fseen_d = flush_tog_s;
    if (pending && (flush_pend || cop_done)) ack_d = req_tog_s;
  end

  always_ff @(posedge cop_clk or negedge cop_rst_n) begin
    if (!cop_rst_n) begin
      ack_q   <= 1'b0;
      fseen_q <= 1'b0;
    end else begin
      ack_q   <= ack_d;
      fseen_q <= fseen_d;
    end
  end

  always_ff @(posedge cop_clk or negedge cop_rst_n) begin
    if (!cop_rst_n)  res_q <= '0;
    else if (res_en) res_q <= cop_result;
  end

  assign cop_instr = pay_instr;
  assign cop_opa   = pay_opa;
  assign cop_opb   = pay_opb;
  assign ack_tog   = ack_q;
  assign res_hold  = res_q;

  // R3
  payload_stable_chk: assert property (@(posedge cop_clk) disable iff (!cop_rst_n)
    (cop_valid && !cop_done) |=> ($stable(cop_instr) && $stable(cop_opa) && $stable(cop_opb)));

  // R8
  cop_flush_drop_chk: assert property (@(posedge cop_clk) disable iff (!cop_rst_n)
    cop_flush |=> !cop_valid);

endmodule

// File: rtl/cop_dispatch.sv
module cop_dispatch
  import cdp_pkg::*;
#(
  parameter int                 XLEN      = 32,
  parameter int                 N_ENT     = 8,
  parameter int                 PRI_W     = 6,
  parameter int                 EXT_W     = 6,
  parameter logic [PRI_W-1:0]   PRI_CODE  = 6'h04,
  parameter logic [2*N_ENT-1:0] CLASS_MAP = 16'hCA50,
  parameter logic [N_ENT-1:0]   WB_MAP    = 8'h14,
  parameter int                 SYNC_N    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cop_clk,
  input  logic            cop_rst_n,
  input  logic            dec_valid,
  input  logic [XLEN-1:0] dec_instr,
  input  logic            cpu_claim,
  output logic            dec_accept,
  output logic            dec_trap,
  output logic            dec_hold,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            cpu_stall,
  input  logic            irq_req,
  output logic            irq_take,
  output logic            flush,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data,
  output logic            cop_valid,
  output logic [XLEN-1:0] cop_instr,
  output logic [XLEN-1:0] cop_opa,
  output logic [XLEN-1:0] cop_opb,
  input  logic            cop_done,
  input  logic [XLEN-1:0] cop_result,
  output logic            cop_flush
);

  localparam int PRI_LSB = XLEN - PRI_W;

  logic            recog, wb;
  xcls_e           cls;
  logic            req_tog, flush_tog, ack_tog, ack_tog_s;
  logic [1:0]      to_cop_s;
  logic [XLEN-1:0] pay_instr, pay_opa, pay_opb, res_hold;

  cdp_decode #(
    .N_ENT(N_ENT), .PRI_W(PRI_W), .EXT_W(EXT_W),
    .PRI_CODE(PRI_CODE), .CLASS_MAP(CLASS_MAP), .WB_MAP(WB_MAP)
  ) u_dec (
    .pri  (dec_instr[PRI_LSB +: PRI_W]),
    .ext  (dec_instr[EXT_W-1:0]),
    .recog(recog),
    .cls  (cls),
    .wb   (wb)
  );

  cdp_cpu_ctrl #(.XLEN(XLEN)) u_cpu (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .cpu_claim (cpu_claim),
    .dec_instr (dec_instr),
    .recog     (recog),
    .cls_in    (cls),
    .wb_in     (wb),
    .src_a     (src_a),
    .src_b     (src_b),
    .irq_req   (irq_req),
    .ack_tog_s (ack_tog_s),
    .res_in    (res_hold),
    .dec_accept(dec_accept),
    .dec_trap  (dec_trap),
    .dec_hold  (dec_hold),
    .cpu_stall (cpu_stall),
    .irq_take  (irq_take),
    .flush     (flush),
    .res_valid (res_valid),
    .res_data  (res_data),
    .req_tog   (req_tog),
    .flush_tog (flush_tog),
    .pay_instr (pay_instr),
    .pay_opa   (pay_opa),
    .pay_opb   (pay_opb)
  );

  // CPU to coprocessor: request and flush toggles.
  cdp_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync_fwd (
    .clk  (cop_clk),
    .rst_n(cop_rst_n),
    .d    ({flush_tog, req_tog}),
    .q    (to_cop_s)
  );

  // Coprocessor to CPU: acknowledge toggle.
  cdp_sync #(.WIDTH(1), .STAGES(SYNC_N)) u_sync_back (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ack_tog),
    .q    (ack_tog_s)
  );

  cdp_cop_port #(.XLEN(XLEN)) u_cop (
    .cop_clk    (cop_clk),
    .cop_rst_n  (cop_rst_n),
    .req_tog_s  (to_cop_s[0]),
    .flush_tog_s(to_cop_s[1]),
    .pay_instr  (pay_instr),
    .pay_opa    (pay_opa),
    .pay_opb    (pay_opb),
    .cop_done   (cop_done),
    .cop_result (cop_result),
    .cop_valid  (cop_valid),
    .cop_flush  (cop_flush),
    .cop_instr  (cop_instr),
    .cop_opa    (cop_opa),
    .cop_opb    (cop_opb),
    .ack_tog    (ack_tog),
    .res_hold   (res_hold)
  );

endmodule

// File: tb/cop_dispatch_bench.sv
module cop_dispatch_bench;

  logic        clk = 1'b0;
  logic        cop_clk = 1'b0;
  logic        rst_n, cop_rst_n;
  logic        dec_valid, cpu_claim, irq_req, cop_done;
  logic [31:0] dec_instr, src_a, src_b, cop_result;
  logic        dec_accept, dec_trap, dec_hold, cpu_stall, irq_take, flush;
  logic        res_valid, cop_valid, cop_flush;
  logic [31:0] res_data, cop_instr, cop_opa, cop_opb;

  int checks = 0;
  int errors = 0;
  int lat = 2;
  int res_cnt = 0;
  logic [31:0] last_res = '0;
  int flush_cnt = 0;
  int start_cnt = 0;
  logic [31:0] cap_instr = '0, cap_a = '0, cap_b = '0;
  logic prev_cv = 1'b0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;
  initial begin
    #7;
    forever #15 cop_clk = ~cop_clk;
  end

  cop_dispatch u_cop_dispatch (
    .clk(clk), .rst_n(rst_n), .cop_clk(cop_clk), .cop_rst_n(cop_rst_n),
    .dec_valid(dec_valid), .dec_instr(dec_instr), .cpu_claim(cpu_claim),
    .dec_accept(dec_accept), .dec_trap(dec_trap), .dec_hold(dec_hold),
    .src_a(src_a), .src_b(src_b), .cpu_stall(cpu_stall),
    .irq_req(irq_req), .irq_take(irq_take), .flush(flush),
    .res_valid(res_valid), .res_data(res_data),
    .cop_valid(cop_valid), .cop_instr(cop_instr), .cop_opa(cop_opa),
    .cop_opb(cop_opb), .cop_done(cop_done), .cop_result(cop_result),
    .cop_flush(cop_flush)
  );

  // {claim, instr, expected accept, expected trap}
  localparam logic [34:0] VEC [12] = '{
    {1'b0, 32'h1000_0000, 1'b1, 1'b0},
    {1'b0, 32'h1000_0002, 1'b1, 1'b0},
    {1'b0, 32'h1000_0004, 1'b1, 1'b0},
    {1'b0, 32'h1000_0006, 1'b1, 1'b0},
    {1'b0, 32'h1000_0007, 1'b0, 1'b1},
    {1'b0, 32'h1000_0008, 1'b0, 1'b1},
    {1'b0, 32'h1000_003F, 1'b0, 1'b1},
    {1'b0, 32'h1400_0002, 1'b0, 1'b1},
    {1'b1, 32'h1000_0000, 1'b0, 1'b0},
    {1'b1, 32'h0000_0000, 1'b0, 1'b0},
    {1'b0, 32'h10AB_CD03, 1'b1, 1'b0},
    {1'b0, 32'h1000_0005, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Coprocessor model: result = a + b + selector, after lat cycles.
  initial begin
    int cnt = 0;
    cop_done = 1'b0;
    cop_result = '0;
    forever begin
      @(negedge cop_clk);
      if (cop_valid) begin
        if (cnt >= lat) begin
          cop_done = 1'b1;
          cop_result = cop_opa + cop_opb + {26'd0, cop_instr[5:0]};
          cnt = 0;
        end else begin
          cop_done = 1'b0;
          cnt++;
        end
      end else begin
        cop_done = 1'b0;
        cnt = 0;
      end
    end
  end

  // Coprocessor-side observation.
  always @(negedge cop_clk) begin
    if (cop_flush) flush_cnt++;
    if (cop_valid && !prev_cv) begin
      start_cnt++;
      cap_instr = cop_instr;
      cap_a = cop_opa;
      cap_b = cop_opb;
    end
    prev_cv = cop_valid;
  end

  // CPU-side result observation.
  always @(negedge clk) begin
    if (res_valid) begin
      res_cnt++;
      last_res = res_data;
    end
  end

  task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    dec_valid = 1'b1; dec_instr = ins; src_a = a; src_b = b;
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  task automatic wait_stall_low(input string req);
    int n = 0;
    while (cpu_stall && n < 2000) begin
      @(negedge clk);
      #1;
      n++;
    end
    chk(req, {31'd0, cpu_stall}, 32'd0);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0;
    int s0;
    int f0;
    rst_n = 1'b0; cop_rst_n = 1'b0;
    dec_valid = 1'b0; cpu_claim = 1'b0; irq_req = 1'b0;
    dec_instr = '0; src_a = '0; src_b = '0;
    #40;
    @(posedge cop_clk); #1 cop_rst_n = 1'b1;
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk); #1;

    // R9 reset state
    chk("R9 stall", {31'd0, cpu_stall}, 0);
    chk("R9 res_valid", {31'd0, res_valid}, 0);
    chk("R9 flush", {31'd0, flush}, 0);
    chk("R9 cop_valid", {31'd0, cop_valid}, 0);
    chk("R9 cop_flush", {31'd0, cop_flush}, 0);

    // R1 / R2 decode vectors, cleared before the next clock edge
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cpu_claim = VEC[i][34]; dec_instr = VEC[i][33:2]; dec_valid = 1'b1;
      #1;
      chk("R1 R2 accept", {31'd0, dec_accept}, {31'd0, VEC[i][1]});
      chk("R1 R2 trap", {31'd0, dec_trap}, {31'd0, VEC[i][0]});
      #1;
      dec_valid = 1'b0; cpu_claim = 1'b0;
    end
    @(negedge clk);
    dec_instr = 32'h1000_0007; #1;
    chk("R1 idle no trap", {31'd0, dec_trap}, 0);
    idle_cycles(4);

    // R5 R7 blocking, result-returning entry 2
    lat = 3;
    issue(32'h1000_0002, 32'd100, 32'd23);
    #1;
    chk("R5 blocking stall", {31'd0, cpu_stall}, 1);
    irq_req = 1'b1; #1;
    chk("R7 blocked irq", {31'd0, irq_take}, 0);
    chk("R7 no flush", {31'd0, flush}, 0);
    r0 = res_cnt;
    wait_stall_low("R5 stall release");
    chk("R5 result strobe", res_cnt, r0 + 1);
    chk("R5 result value", last_res, 32'd125);
    chk("R7 idle irq", {31'd0, irq_take}, 1);
    irq_req = 1'b0;
    chk("R3 instr", cap_instr, 32'h1000_0002);
    chk("R3 opa", cap_a, 32'd100);
    chk("R3 opb", cap_b, 32'd23);
    idle_cycles(4);

    // R4 R6 autonomous entry 1 plus held second request
    lat = 4;
    s0 = start_cnt; r0 = res_cnt;
    issue(32'h1055_0001, 32'h11, 32'h22);
    #1;
    chk("R4 no stall", {31'd0, cpu_stall}, 0);
    dec_valid = 1'b1; dec_instr = 32'h1000_0003; src_a = 32'hDEAD; #1;
    chk("R6 hold", {31'd0, dec_hold}, 1);
    chk("R6 accept", {31'd0, dec_accept}, 1);
    #1 dec_valid = 1'b0;
    idle_cycles(80);
    chk("R4 no result", res_cnt, r0);
    chk("R6 single start", start_cnt, s0 + 1);
    chk("R3 auto instr", cap_instr, 32'h1055_0001);
    chk("R3 auto opa", cap_a, 32'h11);

    // R5 non-autonomous without result, entry 3
    r0 = res_cnt;
    issue(32'h1000_0003, 32'd5, 32'd6);
    #1;
    chk("R5 nowb stall", {31'd0, cpu_stall}, 1);
    wait_stall_low("R5 nowb release");
    idle_cycles(2);
    chk("R5 nowb no result", res_cnt, r0);
    idle_cycles(4);

    // R8 non-blocking entry 4 cancelled by an interrupt
    lat = 40;
    r0 = res_cnt; f0 = flush_cnt;
    issue(32'h1000_0004, 32'd1, 32'd2);
    idle_cycles(12);
    #1;
    chk("R8 stall before irq", {31'd0, cpu_stall}, 1);
    irq_req = 1'b1; #1;
    chk("R8 irq_take", {31'd0, irq_take}, 1);
    chk("R8 flush", {31'd0, flush}, 1);
    @(negedge clk);
    irq_req = 1'b0; #1;
    chk("R8 stall dropped", {31'd0, cpu_stall}, 0);
    dec_valid = 1'b1; dec_instr = 32'h1000_0002; #1;
    chk("R8 draining hold", {31'd0, dec_hold}, 1);
    #1 dec_valid = 1'b0;
    idle_cycles(100);
    chk("R8 cop flush pulse", flush_cnt, f0 + 1);
    chk("R8 no result", res_cnt, r0);

    // R2 non-blocking entry 4 completing normally returns a result
    lat = 2;
    issue(32'h1000_0004, 32'd10, 32'd20);
    wait_stall_low("R2 nb release");
    chk("R2 nb result", last_res, 32'd34);
    chk("R2 nb strobe", res_cnt, r0 + 1);

    done_flag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule